// File: doc/BRIEF.md
# Indexed-enable interrupt controller core

This block collects level-sensitive interrupt lines for a small multi-core system and turns them into one interrupt request line per CPU. Software reaches it through a simple 32-bit read/write bus that shows two windows: a shared window holding the global control, the per-source enables, the per-source routing words and the error cause, and a banked per-CPU window, chosen by a CPU number on the bus, that holds that CPU's masks, error mask, threshold register and acknowledge register.

Enables and masks are never changed by read-modify-write of a bitmap. Software writes a source number to a dedicated set or clear register, and only that one source changes. A CPU finds out what to service by reading its acknowledge register, which returns the lowest-numbered source that is eligible for it, or the all-ones code when there is none. Source 4 does not come from an input pin: it summarises a vector of error cause lines, filtered by a per-CPU error mask.

Bus writes take effect at the clock edge that samples them; read data appears on the cycle after the read strobe. Each IRQ output is registered.

Top module: `intc_core`

## Requirements
- R1: After reset the global enable is 0, every enable is 0, every per-CPU mask bit is 1 (masked), every routing word, error mask and threshold is 0, and every IRQ output is low; the control register at shared offset 0x000 then reads N_SRC in bits [11:2] and 0 elsewhere.
- R2: Bit 0 of the shared control register (offset 0x000) is the global enable; while it is 0 no source is eligible, every IRQ output is low and every acknowledge read gives 0x3FF.
- R3: A write of value n to shared offset 0x030 sets the enable of source n; a write of n to shared offset 0x034 clears it; no other source's enable changes.
- R4: In the window of CPU c (address bit 12 set, CPU number on bus_cpu), a write of n to offset 0x048 masks source n for CPU c only and a write of n to offset 0x04C unmasks it for CPU c only.
- R5: Source n has a routing word at shared offset 0x100 + 4n; bit c routes it as an IRQ to CPU c and bit 8+c is a stored FIQ route; these bits read back and all other bits read 0.
- R6: A read of per-CPU offset 0x044 returns in bits [9:0] the lowest-numbered source that is pending, enabled, unmasked for that CPU and routed to it as an IRQ, with the global enable set; it returns 0x3FF when no source qualifies.
- R7: Source 4 is pending for CPU c when any bit of error cause input err_in is set together with the matching bit of CPU c's error mask (per-CPU offset 0xE50, 1 = pass); src_in[4] is ignored; err_in reads back at shared offset 0x020.
- R8: irq_out[c] is high exactly when at least one source is eligible for CPU c, and follows any enable, mask, route or input change one clock later.
- R9: Enable and mask writes whose 32-bit value is N_SRC or more change nothing; reads of unmapped offsets, of write-only offsets and of a window for a CPU number of N_CPU or more return 0.
- R10: The per-CPU threshold register at offset 0x040 resets to 0 (no blocking), keeps the PRIO_W bits written and reads them back for its own CPU only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_cpu | input | CPU_W | CPU number selecting the banked window |
| bus_addr | input | ADDR_W | Byte address; top bit selects the per-CPU window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| src_in | input | N_SRC | Level-sensitive source lines |
| err_in | input | ERR_BITS | Level-sensitive error cause lines |
| irq_out | output | N_CPU | Registered interrupt request per CPU |

## Verification
The bench builds the block with N_SRC = 40, N_CPU = 2 and ERR_BITS = 6, so the source count readback is a non-power-of-two value, sources above the private range of 32 exist, and out-of-range indices 40 and up can be written cheaply. Two CPUs make it possible to show that masks, routing and the error summary act on one CPU window without disturbing the other. A random phase of mixed enable, mask, routing, error-mask and input changes is compared against a bench model of eligibility and lowest-number selection.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned OFF_W = 12;

    // shared window
    localparam logic [OFF_W-1:0] OFF_CTRL   = 12'h000;
    localparam logic [OFF_W-1:0] OFF_ECAUSE = 12'h020;
    localparam logic [OFF_W-1:0] OFF_ENSET  = 12'h030;
    localparam logic [OFF_W-1:0] OFF_ENCLR  = 12'h034;
    localparam logic [OFF_W-1:0] OFF_ROUTE  = 12'h100;

    // per-CPU window
    localparam logic [OFF_W-1:0] OFF_THRESH = 12'h040;
    localparam logic [OFF_W-1:0] OFF_ACK    = 12'h044;
    localparam logic [OFF_W-1:0] OFF_MSET   = 12'h048;
    localparam logic [OFF_W-1:0] OFF_MCLR   = 12'h04C;
    localparam logic [OFF_W-1:0] OFF_EMASK  = 12'hE50;

    localparam logic [9:0] ACK_NONE = 10'h3FF;
    localparam int unsigned ERR_SRC = 4;
    localparam int unsigned FIQ_LSB = 8;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank #(
    parameter int unsigned N_SRC = 64,
    parameter int unsigned N_CPU = 2,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en_set,
    input  logic                         en_clr,
    input  logic                         rt_wr,
    input  logic [IDX_W-1:0]             rt_idx,
    input  logic [31:0]                  wdata,
    output logic [N_SRC-1:0]             en,
    output logic [N_SRC-1:0][N_CPU-1:0]  irq_rt,
    output logic [N_SRC-1:0][N_CPU-1:0]  fiq_rt
);
    import intc_pkg::*;

    typedef struct packed {
        logic [N_SRC-1:0]            en;
        logic [N_SRC-1:0][N_CPU-1:0] irq_rt;
        logic [N_SRC-1:0][N_CPU-1:0] fiq_rt;
    } bank_t;

    bank_t st_d, st_q;
    logic  idx_ok;
    logic [IDX_W-1:0] idx;

    assign idx_ok = (wdata < 32'(N_SRC));
    assign idx    = wdata[IDX_W-1:0];

    always_comb begin
        st_d = st_q;
        if (en_set && idx_ok) st_d.en[idx] = 1'b1;
        if (en_clr && idx_ok) st_d.en[idx] = 1'b0;
        if (rt_wr) begin
            st_d.irq_rt[rt_idx] = wdata[N_CPU-1:0];
            st_d.fiq_rt[rt_idx] = wdata[FIQ_LSB +: N_CPU];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en     = st_q.en;
    assign irq_rt = st_q.irq_rt;
    assign fiq_rt = st_q.fiq_rt;

    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr && !en_set && idx_ok) |=> !st_q.en[$past(idx)]);

    assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set && !en_clr && idx_ok) |=> st_q.en[$past(idx)]);

    assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_set || en_clr) && !idx_ok && !rt_wr) |=> $stable(st_q.en));
endmodule

// File: rtl/intc_cpu_view.sv
module intc_cpu_view #(
    parameter int unsigned N_SRC    = 64,
    parameter int unsigned ERR_BITS = 8,
    parameter int unsigned PRIO_W   = 4,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gen,
    input  logic [N_SRC-1:0]    en,
    input  logic [N_SRC-1:0]    route,
    input  logic [N_SRC-1:0]    src_in,
    input  logic [ERR_BITS-1:0] err_in,
    input  logic                mask_set,
    input  logic                mask_clr,
    input  logic                emask_wr,
    input  logic                thr_wr,
    input  logic [31:0]         wdata,
    output logic [9:0]          ack_code,
    output logic [ERR_BITS-1:0] emask,
    output logic [PRIO_W-1:0]   thresh,
    output logic                irq
);
    import intc_pkg::*;

    typedef struct packed {
        logic [N_SRC-1:0]    mask;
        logic [ERR_BITS-1:0] emask;
        logic [PRIO_W-1:0]   thresh;
        logic                irq;
    } view_t;

    view_t st_d, st_q;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] elig;
    logic             idx_ok;
    logic [IDX_W-1:0] idx;

    assign idx_ok = (wdata < 32'(N_SRC));
    assign idx    = wdata[IDX_W-1:0];

    // pending vector: source ERR_SRC is the filtered error summary
    always_comb begin
        pend = src_in;
        if (ERR_SRC < N_SRC) pend[ERR_SRC] = |(err_in & st_q.emask);
    end

    assign elig = {N_SRC{gen}} & pend & en & ~st_q.mask & route;

    // lowest-numbered eligible source wins
    always_comb begin
        ack_code = ACK_NONE;
        for (int n = N_SRC - 1; n >= 0; n--) begin
            if (elig[n]) ack_code = 10'(n);
        end
    end

    always_comb begin
        st_d = st_q;
        if (mask_set && idx_ok) st_d.mask[idx] = 1'b1;
        if (mask_clr && idx_ok) st_d.mask[idx] = 1'b0;
        if (emask_wr) st_d.emask  = wdata[ERR_BITS-1:0];
        if (thr_wr)   st_d.thresh = wdata[PRIO_W-1:0];
        st_d.irq = |elig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign emask  = st_q.emask;
    assign thresh = st_q.thresh;
    assign irq    = st_q.irq;

    assert_ack_elig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_code != ACK_NONE) |-> elig[ack_code[IDX_W-1:0]]);

    assert_ack_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_code == ACK_NONE) |-> (elig == '0));

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set && !mask_clr && idx_ok) |=> st_q.mask[$past(idx)]);

    assert_mask_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_set || mask_clr) && !idx_ok) |=> $stable(st_q.mask));
endmodule

// File: rtl/intc_core.sv
module intc_core #(
    parameter int unsigned N_SRC    = 64,
    parameter int unsigned N_CPU    = 2,
    parameter int unsigned ERR_BITS = 8,
    parameter int unsigned PRIO_W   = 4,
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned CPU_W    = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [CPU_W-1:0]    bus_cpu,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [N_SRC-1:0]    src_in,
    input  logic [ERR_BITS-1:0] err_in,
    output logic [N_CPU-1:0]    irq_out
);
    import intc_pkg::*;

    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [OFF_W-1:0] ROUTE_END = OFF_W'(32'(OFF_ROUTE) + 4 * N_SRC);
    localparam logic [9:0] SRC_COUNT = 10'(N_SRC);

    typedef struct packed {
        logic        gen;
        logic [31:0] rdata;
    } top_t;

    top_t st_d, st_q;

    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] rt_off;
    logic             win_cpu;
    logic             cpu_ok;
    logic             in_route;
    logic             sh_wr;
    logic             pc_wr;
    logic [IDX_W-1:0] rt_idx;

    logic [N_SRC-1:0]            en;
    logic [N_SRC-1:0][N_CPU-1:0] irq_rt;
    logic [N_SRC-1:0][N_CPU-1:0] fiq_rt;

    logic [N_CPU-1:0][9:0]          ack_all;
    logic [N_CPU-1:0][ERR_BITS-1:0] emask_all;
    logic [N_CPU-1:0][PRIO_W-1:0]   thr_all;

    assign off      = bus_addr[OFF_W-1:0];
    assign win_cpu  = bus_addr[ADDR_W-1];
    assign cpu_ok   = (32'(bus_cpu) < N_CPU);
    assign in_route = (off >= OFF_ROUTE) && (off < ROUTE_END);
    assign rt_off   = off - OFF_ROUTE;
    assign rt_idx   = rt_off[IDX_W+1:2];
    assign sh_wr    = bus_wr && !win_cpu;
    assign pc_wr    = bus_wr && win_cpu && cpu_ok;

    intc_src_bank #(
        .N_SRC (N_SRC),
        .N_CPU (N_CPU)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_set (sh_wr && off == OFF_ENSET),
        .en_clr (sh_wr && off == OFF_ENCLR),
        .rt_wr  (sh_wr && in_route),
        .rt_idx (rt_idx),
        .wdata  (bus_wdata),
        .en     (en),
        .irq_rt (irq_rt),
        .fiq_rt (fiq_rt)
    );

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic [N_SRC-1:0] route_col;
        logic             sel;

        always_comb begin
            for (int n = 0; n < N_SRC; n++) route_col[n] = irq_rt[n][c];
        end

        assign sel = pc_wr && (32'(bus_cpu) == c);

        intc_cpu_view #(
            .N_SRC    (N_SRC),
            .ERR_BITS (ERR_BITS),
            .PRIO_W   (PRIO_W)
        ) u_view (
            .clk      (clk),
            .rst_n    (rst_n),
            .gen      (st_q.gen),
            .en       (en),
            .route    (route_col),
            .src_in   (src_in),
            .err_in   (err_in),
            .mask_set (sel && off == OFF_MSET),
            .mask_clr (sel && off == OFF_MCLR),
            .emask_wr (sel && off == OFF_EMASK),
            .thr_wr   (sel && off == OFF_THRESH),
            .wdata    (bus_wdata),
            .ack_code (ack_all[c]),
            .emask    (emask_all[c]),
            .thresh   (thr_all[c]),
            .irq      (irq_out[c])
        );
    end

    always_comb begin
        st_d = st_q;
        if (sh_wr && off == OFF_CTRL) st_d.gen = bus_wdata[0];
        st_d.rdata = '0;
        if (bus_rd) begin
            if (!win_cpu) begin
                if (off == OFF_CTRL)
                    st_d.rdata = {20'b0, SRC_COUNT, 1'b0, st_q.gen};
                else if (off == OFF_ECAUSE)
                    st_d.rdata = 32'(err_in);
                else if (in_route) begin
                    st_d.rdata[N_CPU-1:0]         = irq_rt[rt_idx];
                    st_d.rdata[FIQ_LSB +: N_CPU]  = fiq_rt[rt_idx];
                end
            end else if (cpu_ok) begin
                if (off == OFF_ACK)
                    st_d.rdata = {22'b0, ack_all[bus_cpu]};
                else if (off == OFF_THRESH)
                    st_d.rdata = 32'(thr_all[bus_cpu]);
                else if (off == OFF_EMASK)
                    st_d.rdata = 32'(emask_all[bus_cpu]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    assert_gen_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(st_q.gen) |-> (irq_out == '0));

    assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == '0));
endmodule

// File: tb/intc_core_tb.sv
module intc_core_tb;
    localparam int N  = 40;
    localparam int NC = 2;
    localparam int EB = 6;
    localparam logic [12:0] CPUWIN = 13'h1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [0:0]    bus_cpu = '0;
    logic [12:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  src_in = '0;
    logic [EB-1:0] err_in = '0;
    logic [NC-1:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    bit          m_gen;
    bit [N-1:0]  m_en;
    bit [N-1:0]  m_mask [NC];
    bit [N-1:0]  m_rt   [NC];
    bit [EB-1:0] m_emask [NC];

    always #2.5 clk = ~clk;

    intc_core #(.N_SRC(N), .N_CPU(NC), .ERR_BITS(EB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_in(src_in), .err_in(err_in),
        .irq_out(irq_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] m_elig(int c);
        logic [N-1:0] e;
        for (int n = 0; n < N; n++) begin
            bit p = (n == 4) ? |(err_in & m_emask[c]) : src_in[n];
            e[n] = m_gen & p & m_en[n] & ~m_mask[c][n] & m_rt[c][n];
        end
        return e;
    endfunction

    function automatic logic [31:0] m_ack(int c);
        logic [N-1:0] e = m_elig(c);
        for (int n = 0; n < N; n++) if (e[n]) return 32'(n);
        return 32'h3FF;
    endfunction

    task automatic wr(int cpu, logic [12:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_cpu = 1'(cpu); bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int cpu, logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_cpu = 1'(cpu); bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic op_gen(bit v);
        wr(0, 13'h000, 32'(v)); m_gen = v;
    endtask
    task automatic op_en(bit set, int idx);
        wr(0, set ? 13'h030 : 13'h034, 32'(idx));
        if (idx < N) m_en[idx] = set;
    endtask
    task automatic op_mask(int c, bit set, int idx);
        wr(c, CPUWIN | (set ? 13'h048 : 13'h04C), 32'(idx));
        if (idx < N) m_mask[c][idx] = set;
    endtask
    task automatic op_rt(int idx, logic [31:0] v);
        wr(0, 13'(32'h100 + 4 * idx), v);
        for (int c = 0; c < NC; c++) m_rt[c][idx] = v[c];
    endtask
    task automatic op_emask(int c, logic [EB-1:0] v);
        wr(c, CPUWIN | 13'hE50, 32'(v)); m_emask[c] = v;
    endtask

    task automatic check_all(string req);
        logic [31:0] d;
        settle();
        for (int c = 0; c < NC; c++) begin
            chk({req, " irq"}, 32'(irq_out[c]), 32'(|m_elig(c)));
            rd(c, CPUWIN | 13'h044, d);
            chk({req, " ack"}, d, m_ack(c));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        m_gen = 0; m_en = '0;
        for (int c = 0; c < NC; c++) begin
            m_mask[c] = '1; m_rt[c] = '0; m_emask[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, 13'h000, d);            chk("R1 ctrl", d, 32'(N) << 2);
        chk("R1 irq", 32'(irq_out), 0);
        rd(0, CPUWIN | 13'h044, d);   chk("R1 ack0", d, 32'h3FF);
        rd(1, CPUWIN | 13'h044, d);   chk("R1 ack1", d, 32'h3FF);
        rd(1, CPUWIN | 13'h040, d);   chk("R10 thresh reset", d, 0);

        // R2: fully set up source 7 for CPU0 while globally disabled
        src_in[7] = 1'b1;
        op_en(1, 7); op_rt(7, 32'h1); op_mask(0, 0, 7);
        settle();
        chk("R2 irq off", 32'(irq_out), 0);
        rd(0, CPUWIN | 13'h044, d);   chk("R2 ack off", d, 32'h3FF);
        op_gen(1);
        // R8: state updated, irq not yet
        chk("R8 irq latency", 32'(irq_out[0]), 0);
        settle();
        chk("R8 irq0 on", 32'(irq_out[0]), 1);
        chk("R5 irq1 unrouted", 32'(irq_out[1]), 0);
        rd(0, CPUWIN | 13'h044, d);   chk("R6 ack0 src7", d, 7);
        rd(0, 13'h000, d);            chk("R2 ctrl readback", d, (32'(N) << 2) | 1);

        // R6 lowest wins
        src_in[3] = 1'b1;
        op_en(1, 3); op_rt(3, 32'h3); op_mask(0, 0, 3); op_mask(1, 0, 3);
        check_all("R6 lowest");
        // R4 mask on CPU1 only
        op_mask(1, 1, 3);
        check_all("R4 mask cpu1");
        rd(0, CPUWIN | 13'h044, d);   chk("R4 cpu0 keeps 3", d, 3);
        // R3 clear enable of 3 only
        op_en(0, 3);
        check_all("R3 clear");
        rd(0, CPUWIN | 13'h044, d);   chk("R3 src7 stays", d, 7);

        // R9 out of range indices
        op_en(0, N); op_en(0, 1023); op_mask(0, 1, N); op_mask(0, 1, 32'h10007);
        check_all("R9 range");
        rd(0, CPUWIN | 13'h044, d);   chk("R9 src7 unaffected", d, 7);
        rd(0, 13'h010, d);            chk("R9 unmapped", d, 0);
        rd(0, CPUWIN | 13'h048, d);   chk("R9 write-only", d, 0);

        // R5 routing readback
        op_rt(10, 32'hFFFF_FFFF);
        rd(0, 13'h100 + 13'd40, d);   chk("R5 route word", d, 32'h303);

        // R7 error summary on CPU1
        op_en(0, 7); op_en(0, 3); op_en(0, 10);
        src_in[4] = 1'b1;
        op_en(1, 4); op_rt(4, 32'h2); op_mask(1, 0, 4);
        check_all("R7 src_in4 ignored");
        err_in = 6'b000100;
        check_all("R7 emask blocks");
        op_emask(1, 6'b000100);
        check_all("R7 pend");
        rd(1, CPUWIN | 13'h044, d);   chk("R7 ack1", d, 4);
        rd(0, 13'h020, d);            chk("R7 cause", d, 32'h4);
        rd(1, CPUWIN | 13'hE50, d);   chk("R7 emask rb", d, 32'h4);

        // R10 threshold storage per CPU
        wr(1, CPUWIN | 13'h040, 32'h5);
        rd(1, CPUWIN | 13'h040, d);   chk("R10 thresh", d, 5);
        rd(0, CPUWIN | 13'h040, d);   chk("R10 other cpu", d, 0);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int k = int'($urandom_range(0, 7));
            int idx = int'($urandom_range(0, N + 4));
            int c = int'($urandom_range(0, NC - 1));
            case (k)
                0: op_en(1, idx);
                1: op_en(0, idx);
                2: op_mask(c, 0, idx);
                3: op_mask(c, 1, idx);
                4: if (idx < N) op_rt(idx, $urandom());
                5: op_emask(c, EB'($urandom()));
                6: begin
                    @(negedge clk);
                    src_in = {$urandom(), $urandom()} & {$urandom(), $urandom()};
                    err_in = EB'($urandom());
                end
                default: op_gen(($urandom_range(0, 9) != 0));
            endcase
            check_all("R8 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule